// File: doc/BRIEF.md
# Dual-law serial clock divider

This block derives the serial clock for an SPI transfer engine from a faster module clock. One configuration word holds two divisor fields and a law-select bit. In the linear law the ratio is 2×(N+1), with an 8-bit N. In the power-of-two law the ratio is 2^(M+1), with a 4-bit exponent M. Both laws give a 50% duty output. A ratio of 2, which is half the module clock, is the fastest either law can produce.

Besides the divided clock, the block drives two single-cycle strobes for the shifter. The leading strobe marks the cycle in which the clock leaves its idle level. The trailing strobe marks the cycle in which it returns to that level. While the run input is low, the counter is held cleared and the clock sits at the requested idle level.

The configuration word and the idle level are captured once, when a run begins. A change made during a transfer therefore only takes effect from the following start. Firmware computes the field values. The block only applies them.

Top module: `spi_clk_divider`

## Requirements
- R1: While reset is high, and in the first cycle after it, the clock output is 0 and both strobes are 0.
- R2: While run is low, the clock output equals the idle-level input as sampled one cycle earlier, and no strobe fires.
- R3: With cfg bit 12 = 1 (linear law), each half-period of the clock output lasts N+1 module cycles, where N is cfg[7:0].
- R4: With cfg bit 12 = 0 (power-of-two law), each half-period lasts 2^M module cycles, where M is cfg[11:8].
- R5: Suppose run is first sampled high at clock edge k, with half-period H. Then the clock output holds the idle level through edge k+H-1, first changes at edge k+H, and toggles every H edges after that.
- R6: The leading strobe is high for exactly the cycle in which the clock output moves away from the idle level. The trailing strobe is high for exactly the cycle in which it moves back. The two strobes are never high together.
- R7: Changes to cfg or to the idle-level input while run stays high do not alter the running clock. The new values apply from the next start.
- R8: When run is sampled low, the clock output returns to the idle level at that same edge, with no strobe. The next start begins with a full first half-period.
- R9: With N = 0 in the linear law, or M = 0 in the power-of-two law, the clock output toggles on every module cycle (ratio 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| run_i | input | 1 | High while a transfer is active; its rise starts the divider |
| cfg_i | input | 13 | Divider word: [7:0] linear N, [11:8] exponent M, [12] law select (1 = linear) |
| idle_pol_i | input | 1 | Idle level of the serial clock |
| sclk_o | output | 1 | Divided serial clock |
| lead_o | output | 1 | One-cycle strobe on the transition away from the idle level |
| trail_o | output | 1 | One-cycle strobe on the transition back to the idle level |

## Verification
The hardest situation to reach is a configuration change that lands in the middle of a running transfer and must be ignored, followed later by a restart that must adopt it. The stimulus starts a short linear-law run and changes both the divisor and the idle level a few cycles in. It keeps checking the old pattern edge by edge, then drops run and restarts to check the new ratio and level. The largest power-of-two exponent is also driven long enough to see its first transition at the exact edge predicted from 2^15.

// File: rtl/spi_div_pkg.sv
package spi_div_pkg;

  typedef enum logic {
    LAW_POW2   = 1'b0,
    LAW_LINEAR = 1'b1
  } div_law_e;

  typedef struct packed {
    logic lead;
    logic trail;
  } edge_stb_t;

endpackage

// File: rtl/spi_div_cfg.sv
module spi_div_cfg
  import spi_div_pkg::*;
#(
  parameter int LIN_W = 8,
  parameter int EXP_W = 4,
  parameter int CNT_W = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         load_i,
  input  logic [LIN_W+EXP_W:0]         cfg_i,
  input  logic                         idle_pol_i,
  output logic [CNT_W-1:0]             term_o,
  output logic                         pol_o
);

  localparam int MODE_BIT = LIN_W + EXP_W;

  logic [LIN_W-1:0] lin_div;
  logic [EXP_W-1:0] exp_div;
  div_law_e         law;
  logic [CNT_W-1:0] term_next;

  // terminal count = half-period length minus one
  always_comb begin
    lin_div = cfg_i[LIN_W-1:0];
    exp_div = cfg_i[LIN_W +: EXP_W];
    law     = div_law_e'(cfg_i[MODE_BIT]);
    if (law == LAW_LINEAR) begin
      term_next = CNT_W'(lin_div);
    end else begin
      term_next = (CNT_W'(1) << exp_div) - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      term_o <= '0;
      pol_o  <= 1'b0;
    end else if (load_i) begin
      term_o <= term_next;
      pol_o  <= idle_pol_i;
    end
  end

  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (pol_o == $past(idle_pol_i))); // R7

endmodule

// File: rtl/spi_div_count.sv
module spi_div_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active_i,
  input  logic [CNT_W-1:0] term_i,
  output logic             wrap_o
);

  logic [CNT_W-1:0] cnt_q;

  assign wrap_o = active_i && (cnt_q == term_i);

  always_ff @(posedge clk) begin
    if (rst || !active_i || wrap_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    active_i |-> (cnt_q <= term_i)); // R3

  AST_CNT_IDLE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !active_i |=> (cnt_q == '0)); // R8

endmodule

// File: rtl/spi_div_edges.sv
module spi_div_edges
  import spi_div_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic active_i,
  input  logic wrap_i,
  input  logic pol_i,
  input  logic idle_pol_i,
  output logic sclk_o,
  output logic lead_o,
  output logic trail_o
);

  edge_stb_t stb_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_o <= 1'b0;
      stb_q  <= '0;
    end else if (!active_i) begin
      sclk_o <= idle_pol_i;
      stb_q  <= '0;
    end else if (wrap_i) begin
      sclk_o      <= ~sclk_o;
      stb_q.lead  <= (sclk_o == pol_i);
      stb_q.trail <= (sclk_o != pol_i);
    end else begin
      stb_q <= '0;
    end
  end

  assign lead_o  = stb_q.lead;
  assign trail_o = stb_q.trail;

  AST_STB_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(lead_o && trail_o)); // R6

  AST_IDLE_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    !active_i |=> (sclk_o == $past(idle_pol_i)) && !lead_o && !trail_o); // R2

  AST_STB_ON_CHANGE: assert property (@(posedge clk) disable iff (rst)
    (lead_o || trail_o) |-> (sclk_o != $past(sclk_o))); // R6

  AST_LEAD_SPACING: assert property (@(posedge clk) disable iff (rst)
    lead_o |=> !lead_o); // R9

endmodule

// File: rtl/spi_clk_divider.sv
module spi_clk_divider
  import spi_div_pkg::*;
#(
  parameter int LIN_W = 8,
  parameter int EXP_W = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 run_i,
  input  logic [LIN_W+EXP_W:0] cfg_i,
  input  logic                 idle_pol_i,
  output logic                 sclk_o,
  output logic                 lead_o,
  output logic                 trail_o
);

  localparam int POW_W = (1 << EXP_W);
  localparam int LIN_C = LIN_W + 1;
  localparam int CNT_W = (POW_W > LIN_C) ? POW_W : LIN_C;

  logic             active_q;
  logic             start;
  logic             active;
  logic [CNT_W-1:0] term;
  logic             pol;
  logic             wrap;

  always_ff @(posedge clk) begin
    if (rst) active_q <= 1'b0;
    else     active_q <= run_i;
  end

  assign start  = run_i && !active_q;
  assign active = run_i && active_q;

  spi_div_cfg #(.LIN_W(LIN_W), .EXP_W(EXP_W), .CNT_W(CNT_W)) u_cfg (
    .clk        (clk),
    .rst        (rst),
    .load_i     (start),
    .cfg_i      (cfg_i),
    .idle_pol_i (idle_pol_i),
    .term_o     (term),
    .pol_o      (pol)
  );

  spi_div_count #(.CNT_W(CNT_W)) u_count (
    .clk      (clk),
    .rst      (rst),
    .active_i (active),
    .term_i   (term),
    .wrap_o   (wrap)
  );

  spi_div_edges u_edges (
    .clk        (clk),
    .rst        (rst),
    .active_i   (active),
    .wrap_i     (wrap),
    .pol_i      (pol),
    .idle_pol_i (idle_pol_i),
    .sclk_o     (sclk_o),
    .lead_o     (lead_o),
    .trail_o    (trail_o)
  );

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    (run_i && active_q) |=> ($stable(term) && $stable(pol))); // R7

  AST_STB_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
    (lead_o || trail_o) |-> $past(run_i)); // R8

endmodule

// File: tb/spi_clk_divider_bench.sv
module spi_clk_divider_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run_i = 1'b0;
  logic [12:0] cfg_i = '0;
  logic        idle_pol_i = 1'b0;
  logic        sclk_o, lead_o, trail_o;

  int checks = 0;
  int bad = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  spi_clk_divider u_spi_clk_divider (
    .clk(clk), .rst(rst), .run_i(run_i), .cfg_i(cfg_i),
    .idle_pol_i(idle_pol_i), .sclk_o(sclk_o), .lead_o(lead_o), .trail_o(trail_o)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      bad = bad + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
      $display("  test done: total=%0d bad=%0d", checks + 1, bad);
      $finish;
    end
  end

  function automatic logic [12:0] lin_cfg(input int n);
    return {1'b1, 4'd0, 8'(n)};
  endfunction

  function automatic logic [12:0] pow_cfg(input int m);
    return {1'b0, 4'(m), 8'd0};
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // compares the output triple {sclk,lead,trail} against the pattern for one
  // half-period length, for cycles j=from..len after the start edge
  task automatic follow(input logic pol, input int half, input int from, input int len,
                        inout int errs, inout int fa, inout int fe);
    for (int j = from; j <= len; j++) begin
      int ph;
      logic es, el, et, edg;
      if (j > from || from > 0) @(negedge clk);
      ph  = j / half;
      edg = (j > 0) && (j % half == 0);
      es  = pol ^ ph[0];
      el  = edg && ph[0];
      et  = edg && !ph[0];
      if ({sclk_o, lead_o, trail_o} !== {es, el, et}) begin
        if (errs == 0) begin fa = {sclk_o, lead_o, trail_o}; fe = {es, el, et}; end
        errs++;
      end
    end
  endtask

  task automatic run_pattern(input logic [12:0] cfg, input logic pol, input int half,
                             input int len, input string req);
    int errs = 0, fa = 0, fe = 0;
    cfg_i = cfg; idle_pol_i = pol; run_i = 1'b1;
    @(negedge clk);
    follow(pol, half, 0, len, errs, fa, fe);
    check(errs == 0, req, fa, fe);
    run_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check({sclk_o, lead_o, trail_o} == 3'b000, "R1 in reset", {sclk_o, lead_o, trail_o}, 0);
    rst = 1'b0;
    @(negedge clk);
    check({sclk_o, lead_o, trail_o} == 3'b000, "R1 after reset", {sclk_o, lead_o, trail_o}, 0);
  endtask

  task automatic t_idle;
    int errs = 0;
    for (int i = 0; i < 8; i++) begin
      idle_pol_i = i[1];
      @(negedge clk);
      if ({sclk_o, lead_o, trail_o} !== {idle_pol_i, 2'b00}) errs++;
    end
    check(errs == 0, "R2 idle follows level", errs, 0);
    idle_pol_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_linear;
    run_pattern(lin_cfg(3), 1'b0, 4, 40, "R3 linear N=3");
    run_pattern(lin_cfg(6), 1'b1, 7, 50, "R3 linear N=6 idle high");
    run_pattern(lin_cfg(255), 1'b0, 256, 1100, "R3 linear N=255");
  endtask

  task automatic t_pow2;
    run_pattern(pow_cfg(2), 1'b0, 4, 40, "R4 pow2 M=2");
    run_pattern(pow_cfg(5), 1'b1, 32, 200, "R4 pow2 M=5");
    run_pattern(pow_cfg(15), 1'b0, 32768, 32770, "R5 pow2 M=15 first edge");
  endtask

  task automatic t_first_edge;
    run_pattern(lin_cfg(9), 1'b1, 10, 25, "R5 first edge after H");
    run_pattern(lin_cfg(1), 1'b0, 2, 20, "R6 strobes linear N=1");
  endtask

  task automatic t_min_ratio;
    run_pattern(lin_cfg(0), 1'b0, 1, 16, "R9 linear N=0");
    run_pattern(pow_cfg(0), 1'b1, 1, 16, "R9 pow2 M=0");
  endtask

  task automatic t_cfg_change;
    int errs = 0, fa = 0, fe = 0;
    cfg_i = lin_cfg(2); idle_pol_i = 1'b0; run_i = 1'b1;
    @(negedge clk);
    follow(1'b0, 3, 0, 5, errs, fa, fe);
    cfg_i = lin_cfg(9); idle_pol_i = 1'b1;
    follow(1'b0, 3, 6, 30, errs, fa, fe);
    check(errs == 0, "R7 mid-run change ignored", fa, fe);
    run_i = 1'b0;
    @(negedge clk);
    run_pattern(lin_cfg(9), 1'b1, 10, 40, "R7 new setting at restart");
  endtask

  task automatic t_stop;
    int errs = 0, fa = 0, fe = 0;
    cfg_i = lin_cfg(4); idle_pol_i = 1'b0; run_i = 1'b1;
    @(negedge clk);
    follow(1'b0, 5, 0, 7, errs, fa, fe);
    check(sclk_o == 1'b1, "R8 mid-phase active level", sclk_o, 1);
    run_i = 1'b0;
    @(negedge clk);
    check({sclk_o, lead_o, trail_o} == 3'b000, "R8 stop returns idle no strobe",
          {sclk_o, lead_o, trail_o}, 0);
    errs = 0;
    repeat (4) begin
      @(negedge clk);
      if (lead_o || trail_o) errs++;
    end
    check(errs == 0, "R8 no strobes after stop", errs, 0);
    run_pattern(lin_cfg(4), 1'b0, 5, 30, "R8 restart full first half");
  endtask

  initial begin
    t_reset();
    t_idle();
    t_linear();
    t_pow2();
    t_first_edge();
    t_min_ratio();
    t_cfg_change();
    t_stop();
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule